// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Prioritiser

This block collects the interrupt conditions of a two-channel serial controller and turns them into one interrupt line, a six-bit pending word and an eight-bit vector status code. Each channel tracks a receive request, a transmit request and a break request. It also keeps a service state that records whether receive, transmit or both currently hold in-service status. Channel A is index 0 and channel B is index 1 on every two-bit port.

The host side of the controller drives single-cycle strobes into the block. These are a character arrival, a transmit buffer becoming empty, a data-port read, a data-port write, and a control-port command whose three-bit code comes from bits 5:3 of the command byte. Enable levels come from the controller's mode registers. On each channel, at most one of rx_char, tx_empty, data_rd, data_wr and cmd_we may be high in any cycle. A strobe takes effect at the next rising clock edge. The outputs are combinational from the registered state and the current level inputs.

The service state of a channel is a four-state machine: SV_IDLE (nothing in service), SV_RX (receive in service), SV_TX (transmit in service) and SV_RX_TX (both in service). The transitions are as follows:
- A character arrival moves SV_IDLE to SV_RX and moves SV_TX to SV_RX_TX.
- A buffer-empty strobe moves SV_IDLE to SV_TX only when receive is not in service.
- A data read leaves receive out of service. The state becomes SV_TX if transmit is pending or was already in service, and SV_IDLE otherwise.
- Clear-transmit (code 101) removes transmit service. It re-enters SV_RX when receive is still pending.
- Reset-highest-in-service (code 111) clears receive service if it is held. The state then becomes SV_TX if transmit is waiting or already in service, and SV_IDLE otherwise. When receive is not in service, the command drops SV_TX to SV_IDLE.

Top module: `irqv_prio_unit`

## Requirements
- R1: After reset, irq_o is 0, pend_o is 0, rx_avail_o is 0 and vector_o is 0x06 while status_hi_i is 0.
- R2: A rx_char strobe sets that channel's receive pending flag, its rx_avail_o bit and receive in-service.
- R3: A tx_empty strobe sets transmit pending. Transmit takes in-service status only when receive is not in service, and only then sets the pending-word transmit bit (if tx_ie is 1).
- R4: A channel requests when (transmit pending and tx_ie=1), or (receive pending and rx_mode is 01 or 10), or (brk and brk_ie both 1). irq_o is the OR of both channels' requests.
- R5: With status_hi_i=0 the vector is chosen from in-service flags in the order rx A, tx A, rx B, tx B. The codes are rx A 0x0C, tx A 0x08, rx B 0x04, tx B 0x00, and 0x06 when nothing is in service.
- R6: With status_hi_i=1 the codes under the same order are rx A 0x30, tx A 0x10, rx B 0x20, tx B 0x00, and none 0x60.
- R7: pend_o holds bit0 break B, bit1 tx B, bit2 rx B, bit3 break A, bit4 tx A and bit5 rx A. The rx bit is the receive pending flag. The break bit is brk AND brk_ie.
- R8: Command code 101 clears transmit pending, transmit in-service and the pending-word tx bit, and re-asserts receive in-service if receive is still pending.
- R9: Command code 111 clears receive in-service when it is set, and a waiting transmit request then takes service. Otherwise the command clears transmit in-service.
- R10: A data_rd strobe clears rx_avail_o and receive pending and receive in-service. A pending transmit request then takes service.
- R11: A data_wr strobe clears transmit pending. A tx_empty strobe in the very next cycle raises it again.
- R12: Command codes other than 101 and 111 leave irq_o, pend_o, vector_o and rx_avail_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_char_i | input | 2 | Character received strobe per channel |
| tx_empty_i | input | 2 | Transmit buffer empty strobe per channel |
| data_rd_i | input | 2 | Data port read strobe per channel |
| data_wr_i | input | 2 | Data port write strobe per channel |
| cmd_we_i | input | 2 | Command strobe per channel |
| cmd_code_i | input | 6 | Command code, channel c at [3c+2:3c] |
| tx_ie_i | input | 2 | Transmit interrupt enable per channel |
| rx_mode_i | input | 4 | Receive interrupt mode, channel c at [2c+1:2c] |
| brk_i | input | 2 | Break condition level per channel |
| brk_ie_i | input | 2 | Break interrupt enable per channel |
| status_hi_i | input | 1 | Selects high-nibble vector codes |
| irq_o | output | 1 | Combined interrupt request, active high |
| pend_o | output | 6 | Pending word |
| vector_o | output | 8 | Vector status code |
| rx_avail_o | output | 2 | Character available per channel |

## Verification
Directed sequences cover the handover cases on their own. Receive arriving before a buffer-empty event shows whether receive service blocks transmit. The reset-highest-in-service command and a data read each show whether the waiting transmit request takes over. A write followed at once by buffer-empty shows the transmit request dropping and then returning. Switching status_hi_i with both channels in service separates the low and high code sets and the rx A, tx A, rx B, tx B ordering. Random strobe streams on both channels, with random command codes and enable levels, then mix overlapping requests, no-op commands and masked receive modes against a bench model of the flags.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    typedef enum logic [1:0] {
        SV_IDLE  = 2'd0,
        SV_RX    = 2'd1,
        SV_TX    = 2'd2,
        SV_RX_TX = 2'd3
    } svc_state_t;

    localparam logic [2:0] CMD_CLR_TX  = 3'b101;
    localparam logic [2:0] CMD_CLR_IUS = 3'b111;

    // kind: 0 rx, 1 tx, 2 none
    function automatic logic [7:0] vec_code(input logic hi, input logic chan_b, input logic [1:0] kind);
        logic [7:0] c;
        if (kind == 2'd2)      c = hi ? 8'h60 : 8'h06;
        else if (kind == 2'd0) c = hi ? (chan_b ? 8'h20 : 8'h30) : (chan_b ? 8'h04 : 8'h0C);
        else                   c = chan_b ? 8'h00 : (hi ? 8'h10 : 8'h08);
        return c;
    endfunction
endpackage

// File: rtl/irqv_chan.sv
module irqv_chan
    import irqv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_char,
    input  logic       tx_empty,
    input  logic       data_rd,
    input  logic       data_wr,
    input  logic       cmd_we,
    input  logic [2:0] cmd_code,
    input  logic       tx_ie,
    input  logic [1:0] rx_mode,
    input  logic       brk,
    input  logic       brk_ie,
    output logic       req_o,
    output logic       rx_pend_o,
    output logic       tx_pend_o,
    output logic       rx_svc_o,
    output logic       tx_svc_o,
    output logic       tx_flag_o,
    output logic       ext_flag_o,
    output logic       rx_avail_o
);
    svc_state_t state_q, state_d;
    logic rx_pend_q, tx_pend_q, tx_flag_q, rx_avail_q;
    logic clr_tx, clr_ius, rx_svc, tx_svc, tx_take;

    assign clr_tx  = cmd_we && (cmd_code == CMD_CLR_TX);
    assign clr_ius = cmd_we && (cmd_code == CMD_CLR_IUS);
    assign rx_svc  = (state_q == SV_RX) || (state_q == SV_RX_TX);
    assign tx_svc  = (state_q == SV_TX) || (state_q == SV_RX_TX);
    assign tx_take = (tx_empty && !rx_svc) || (data_rd && tx_pend_q)
                   || (clr_ius && rx_svc && tx_pend_q);

    // next service state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SV_IDLE: begin
                if (rx_char)                      state_d = SV_RX;
                else if (tx_empty)                state_d = SV_TX;
                else if (data_rd && tx_pend_q)    state_d = SV_TX;
                else if (clr_tx && rx_pend_q)     state_d = SV_RX;
            end
            SV_RX: begin
                if (data_rd || clr_ius)           state_d = tx_pend_q ? SV_TX : SV_IDLE;
            end
            SV_TX: begin
                if (rx_char)                      state_d = SV_RX_TX;
                else if (clr_tx)                  state_d = rx_pend_q ? SV_RX : SV_IDLE;
                else if (clr_ius)                 state_d = SV_IDLE;
            end
            SV_RX_TX: begin
                if (data_rd || clr_ius)           state_d = SV_TX;
                else if (clr_tx)                  state_d = SV_RX;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SV_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_pend_q  <= 1'b0;
            tx_pend_q  <= 1'b0;
            tx_flag_q  <= 1'b0;
            rx_avail_q <= 1'b0;
        end else begin
            if (rx_char) begin
                rx_pend_q  <= 1'b1;
                rx_avail_q <= 1'b1;
            end else if (data_rd) begin
                rx_pend_q  <= 1'b0;
                rx_avail_q <= 1'b0;
            end
            if (tx_empty)                tx_pend_q <= 1'b1;
            else if (data_wr || clr_tx)  tx_pend_q <= 1'b0;
            if (clr_tx)                  tx_flag_q <= 1'b0;
            else if (tx_take && tx_ie)   tx_flag_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        ext_flag_o = brk && brk_ie;
        req_o      = (tx_pend_q && tx_ie)
                   || (rx_pend_q && (rx_mode == 2'b01 || rx_mode == 2'b10))
                   || ext_flag_o;
        rx_pend_o  = rx_pend_q;
        tx_pend_o  = tx_pend_q;
        rx_svc_o   = rx_svc;
        tx_svc_o   = tx_svc;
        tx_flag_o  = tx_flag_q;
        rx_avail_o = rx_avail_q;
    end

    AST_RX_TAKES_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        rx_char |=> rx_svc_o && rx_pend_o && rx_avail_o); // R2
    AST_TX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && rx_svc) |=> tx_pend_o && (tx_svc_o == $past(tx_svc))); // R3
    AST_CLR_TX: assert property (@(posedge clk) disable iff (!rst_n)
        clr_tx |=> !tx_pend_o && !tx_svc_o && !tx_flag_o); // R8
    AST_IUS_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ius && rx_svc && tx_pend_q) |=> !rx_svc_o && tx_svc_o); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd |=> !rx_pend_o && !rx_avail_o && !rx_svc_o); // R10
    AST_WRITE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !tx_pend_o); // R11
endmodule

// File: rtl/irqv_vec.sv
module irqv_vec
    import irqv_pkg::*;
(
    input  logic [1:0] rx_svc,
    input  logic [1:0] tx_svc,
    input  logic       status_hi,
    output logic [7:0] vec_o
);
    always_comb begin
        if (rx_svc[0])      vec_o = vec_code(status_hi, 1'b0, 2'd0);
        else if (tx_svc[0]) vec_o = vec_code(status_hi, 1'b0, 2'd1);
        else if (rx_svc[1]) vec_o = vec_code(status_hi, 1'b1, 2'd0);
        else if (tx_svc[1]) vec_o = vec_code(status_hi, 1'b1, 2'd1);
        else                vec_o = vec_code(status_hi, 1'b0, 2'd2);
    end
endmodule

// File: rtl/irqv_prio_unit.sv
module irqv_prio_unit
    import irqv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rx_char_i,
    input  logic [1:0] tx_empty_i,
    input  logic [1:0] data_rd_i,
    input  logic [1:0] data_wr_i,
    input  logic [1:0] cmd_we_i,
    input  logic [5:0] cmd_code_i,
    input  logic [1:0] tx_ie_i,
    input  logic [3:0] rx_mode_i,
    input  logic [1:0] brk_i,
    input  logic [1:0] brk_ie_i,
    input  logic       status_hi_i,
    output logic       irq_o,
    output logic [5:0] pend_o,
    output logic [7:0] vector_o,
    output logic [1:0] rx_avail_o
);
    localparam int NCH   = 2;
    localparam int PBITS = 3;

    logic [NCH-1:0] req, rx_pend, tx_pend, rx_svc, tx_svc, tx_flag, ext_flag;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam int BASE = PBITS * (NCH - 1 - c);
        irqv_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .rx_char    (rx_char_i[c]),
            .tx_empty   (tx_empty_i[c]),
            .data_rd    (data_rd_i[c]),
            .data_wr    (data_wr_i[c]),
            .cmd_we     (cmd_we_i[c]),
            .cmd_code   (cmd_code_i[3*c +: 3]),
            .tx_ie      (tx_ie_i[c]),
            .rx_mode    (rx_mode_i[2*c +: 2]),
            .brk        (brk_i[c]),
            .brk_ie     (brk_ie_i[c]),
            .req_o      (req[c]),
            .rx_pend_o  (rx_pend[c]),
            .tx_pend_o  (tx_pend[c]),
            .rx_svc_o   (rx_svc[c]),
            .tx_svc_o   (tx_svc[c]),
            .tx_flag_o  (tx_flag[c]),
            .ext_flag_o (ext_flag[c]),
            .rx_avail_o (rx_avail_o[c])
        );
        assign pend_o[BASE]     = ext_flag[c];
        assign pend_o[BASE + 1] = tx_flag[c];
        assign pend_o[BASE + 2] = rx_pend[c];
    end

    assign irq_o = |req;

    irqv_vec u_vec (
        .rx_svc    (rx_svc),
        .tx_svc    (tx_svc),
        .status_hi (status_hi_i),
        .vec_o     (vector_o)
    );

    AST_VEC_RX_A: assert property (@(posedge clk) disable iff (!rst_n)
        rx_svc[0] |-> (vector_o == 8'h0C || vector_o == 8'h30)); // R5
    AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_svc == 2'b00 && tx_svc == 2'b00) |-> (vector_o == 8'h06 || vector_o == 8'h60)); // R6
    AST_IRQ_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pend[0] && tx_ie_i[0]) |-> irq_o); // R4
endmodule

// File: tb/irqv_prio_unit_tb.sv
module irqv_prio_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] rx_char_i = '0, tx_empty_i = '0, data_rd_i = '0, data_wr_i = '0, cmd_we_i = '0;
    logic [5:0] cmd_code_i = '0;
    logic [1:0] tx_ie_i = '0, brk_i = '0, brk_ie_i = '0;
    logic [3:0] rx_mode_i = '0;
    logic       status_hi_i = 1'b0;
    logic       irq_o;
    logic [5:0] pend_o;
    logic [7:0] vector_o;
    logic [1:0] rx_avail_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model of flags
    bit m_rxp[2], m_rxs[2], m_txp[2], m_txs[2], m_txf[2], m_av[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    irqv_prio_unit u_dut (
        .clk(clk), .rst_n(rst_n), .rx_char_i(rx_char_i), .tx_empty_i(tx_empty_i),
        .data_rd_i(data_rd_i), .data_wr_i(data_wr_i), .cmd_we_i(cmd_we_i),
        .cmd_code_i(cmd_code_i), .tx_ie_i(tx_ie_i), .rx_mode_i(rx_mode_i),
        .brk_i(brk_i), .brk_ie_i(brk_ie_i), .status_hi_i(status_hi_i),
        .irq_o(irq_o), .pend_o(pend_o), .vector_o(vector_o), .rx_avail_o(rx_avail_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_vec();
        logic hi;
        hi = status_hi_i;
        if (m_rxs[0]) return hi ? 8'h30 : 8'h0C;
        if (m_txs[0]) return hi ? 8'h10 : 8'h08;
        if (m_rxs[1]) return hi ? 8'h20 : 8'h04;
        if (m_txs[1]) return 8'h00;
        return hi ? 8'h60 : 8'h06;
    endfunction

    function automatic logic [5:0] exp_pend();
        logic [5:0] p;
        p = '0;
        for (int c = 0; c < 2; c++) begin
            p[3*(1-c)]     = brk_i[c] & brk_ie_i[c];
            p[3*(1-c) + 1] = m_txf[c];
            p[3*(1-c) + 2] = m_rxp[c];
        end
        return p;
    endfunction

    function automatic logic exp_irq();
        logic r;
        r = 1'b0;
        for (int c = 0; c < 2; c++) begin
            logic [1:0] md;
            md = rx_mode_i[2*c +: 2];
            r |= (m_txp[c] & tx_ie_i[c]) | (m_rxp[c] & (md == 2'b01 || md == 2'b10))
               | (brk_i[c] & brk_ie_i[c]);
        end
        return r;
    endfunction

    // ev: 0 none, 1 rx char, 2 tx empty, 3 read, 4 write, 5 command
    task automatic model(input int c, input int ev, input logic [2:0] code);
        case (ev)
            1: begin m_rxp[c] = 1; m_av[c] = 1; m_rxs[c] = 1; end
            2: begin
                m_txp[c] = 1;
                if (!m_rxs[c]) begin m_txs[c] = 1; if (tx_ie_i[c]) m_txf[c] = 1; end
            end
            3: begin
                m_rxp[c] = 0; m_av[c] = 0; m_rxs[c] = 0;
                if (m_txp[c]) begin m_txs[c] = 1; if (tx_ie_i[c]) m_txf[c] = 1; end
            end
            4: m_txp[c] = 0;
            5: begin
                if (code == 3'b101) begin
                    m_txp[c] = 0; m_txs[c] = 0; m_txf[c] = 0;
                    if (m_rxp[c]) m_rxs[c] = 1;
                end else if (code == 3'b111) begin
                    if (m_rxs[c]) begin
                        m_rxs[c] = 0;
                        if (m_txp[c]) begin m_txs[c] = 1; if (tx_ie_i[c]) m_txf[c] = 1; end
                    end else m_txs[c] = 0;
                end
            end
            default: ;
        endcase
    endtask

    task automatic drive(input int c, input int ev, input logic [2:0] code);
        rx_char_i[c]  = (ev == 1);
        tx_empty_i[c] = (ev == 2);
        data_rd_i[c]  = (ev == 3);
        data_wr_i[c]  = (ev == 4);
        cmd_we_i[c]   = (ev == 5);
        cmd_code_i[3*c +: 3] = code;
    endtask

    task automatic check_all();
        chk("R4 irq", {7'd0, irq_o}, {7'd0, exp_irq()});
        chk("R7 pend", {2'd0, pend_o}, {2'd0, exp_pend()});
        chk(status_hi_i ? "R6 vector" : "R5 vector", vector_o, exp_vec());
        chk("R2 rx_avail", {6'd0, rx_avail_o}, {6'd0, m_av[1], m_av[0]});
    endtask

    // caller is at a negedge; returns at the next negedge
    task automatic step(input int ea, input logic [2:0] ca, input int eb, input logic [2:0] cb);
        drive(0, ea, ca);
        drive(1, eb, cb);
        @(negedge clk);
        drive(0, 0, 3'd0);
        drive(1, 0, 3'd0);
        model(0, ea, ca);
        model(1, eb, cb);
        check_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            m_rxp[c] = 0; m_rxs[c] = 0; m_txp[c] = 0; m_txs[c] = 0; m_txf[c] = 0; m_av[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        chk("R1 pend", {2'd0, pend_o}, 8'h00);
        chk("R1 vector", vector_o, 8'h06);
        chk("R1 rx_avail", {6'd0, rx_avail_o}, 8'h00);

        tx_ie_i = 2'b11;
        rx_mode_i = 4'b0101;
        // R3 receive service blocks transmit
        step(1, 3'd0, 0, 3'd0);
        step(2, 3'd0, 0, 3'd0);
        chk("R3 vector stays rx A", vector_o, 8'h0C);
        chk("R3 pend no tx bit", {2'd0, pend_o}, 8'h20);
        // R9 reset-in-service hands over to transmit
        step(5, 3'b111, 0, 3'd0);
        chk("R9 vector tx A", vector_o, 8'h08);
        chk("R9 pend", {2'd0, pend_o}, 8'h30);
        // R10 data read clears receive
        step(3, 3'd0, 0, 3'd0);
        chk("R10 pend", {2'd0, pend_o}, 8'h10);
        chk("R10 rx_avail", {6'd0, rx_avail_o}, 8'h00);
        // R8 clear transmit
        step(5, 3'b101, 0, 3'd0);
        chk("R8 pend", {2'd0, pend_o}, 8'h00);
        chk("R8 vector", vector_o, 8'h06);
        chk("R8 irq", {7'd0, irq_o}, 8'h00);
        // R11 write then buffer empty next cycle
        step(2, 3'd0, 0, 3'd0);
        step(4, 3'd0, 0, 3'd0);
        chk("R11 irq dropped", {7'd0, irq_o}, 8'h00);
        step(2, 3'd0, 0, 3'd0);
        chk("R11 irq back", {7'd0, irq_o}, 8'h01);
        // R6 status-high codes and order
        status_hi_i = 1'b1;
        step(0, 3'd0, 1, 3'd0);
        chk("R6 tx A over rx B", vector_o, 8'h10);
        step(5, 3'b101, 0, 3'd0);
        chk("R6 rx B", vector_o, 8'h20);
        // R12 no-op command
        step(0, 3'd0, 5, 3'b010);
        chk("R12 pend", {2'd0, pend_o}, 8'h04);
        chk("R12 vector", vector_o, 8'h20);
        // R5 status-low rx B
        status_hi_i = 1'b0;
        @(negedge clk);
        chk("R5 rx B", vector_o, 8'h04);
        // R4 mask mode and break
        rx_mode_i = 4'b1101;
        @(negedge clk);
        chk("R4 rx mode 11 masked", {7'd0, irq_o}, 8'h00);
        brk_i = 2'b10; brk_ie_i = 2'b10;
        @(negedge clk);
        chk("R4 break request", {7'd0, irq_o}, 8'h01);
        chk("R7 break B bit", {2'd0, pend_o}, 8'h05);
        brk_i = 2'b00; brk_ie_i = 2'b00;
        @(negedge clk);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int ev[2];
            logic [2:0] cd[2];
            if (i % 64 == 0) begin
                tx_ie_i = 2'($urandom);
                rx_mode_i = 4'($urandom);
                brk_i = 2'($urandom);
                brk_ie_i = 2'($urandom);
                status_hi_i = 1'($urandom);
            end
            for (int c = 0; c < 2; c++) begin
                int r;
                r = int'($urandom % 8);
                ev[c] = (r < 2) ? 0 : (r >= 6 ? 5 : r - 1);
                cd[c] = 3'($urandom);
            end
            step(ev[0], cd[0], ev[1], cd[1]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule